// File: doc/BRIEF.md
# Interrupt Sense Normalizing Front End

This block sits between up to 126 wakeup interrupt pins and a parent interrupt controller that only understands two signal forms: a level that is asserted high, and a rising edge. Each pin carries a small sense code that says how its source signals an event: low level, high level, falling edge, rising edge or either edge. The block turns every pin into one of the two forms the parent accepts, and forwards it only while that pin's enable bit is set.

Each pin is first brought into the clock domain through a two-flop synchronizer. Level pins are corrected for polarity and passed on. Edge pins are first corrected for polarity. Each one is then compared with a registered copy of its previous corrected value, which produces a one-cycle pulse. Software programs the block through a plain word-wide register port. The port holds banks of enable bits and one configuration word per pin. Writing a pin's configuration reloads its stored previous value, so a change of sense cannot on its own produce an event.

Top module: `wakeIrqNormalizer`

## Requirements
- R1: After reset every output is low, every enable bit is clear and every configuration word reads as zero.
- R2: The enable bit of pin n is bit n%32 of the 32-bit word at byte address 0x10 + 4*(n/32). Bits of a bank that name no existing pin read as zero.
- R3: The configuration word of pin n is at byte address 0x110 + 4*n. Only its low 3 bits are stored, and reads return them zero-extended. Reads of any other address return zero.
- R4: Sense code 3'b100 (high level): the output equals the pin input two clock edges after the input changes, for as long as the input holds.
- R5: Sense code 3'b000 (low level): the output is the inverse of the pin input, with the same two-edge latency.
- R6: Sense code 3'b110 (rising edge): a rising input yields exactly one output cycle high, two edges after the change. A falling input yields nothing.
- R7: Sense code 3'b010 (falling edge): a falling input yields exactly one output cycle high. A rising input yields nothing.
- R8: Sense code 3'b111 (either edge): every input transition yields exactly one output cycle high.
- R9: The undefined sense codes 3'b001, 3'b011 and 3'b101 hold the output low whatever the input does.
- R10: A pin whose enable bit is clear never drives its output high.
- R11: Writing a new sense code while the pin input is steady produces no output pulse. This holds even when the new code inverts the polarity the pin had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe, one word per cycle |
| regAddr | input | 12 | Byte address of the register word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| pinIn | input | NUM_PINS | Raw asynchronous interrupt pins |
| irqOut | output | NUM_PINS | Normalized, gated outputs toward the parent |

## Verification
The hardest case to reach from the ports is a sense change that flips polarity on a pin that is already steady. If the previous-value register were not reloaded, a false edge would appear in the cycle right after the configuration write. The bench parks a pin at a known level under one edge code and rewrites it to the opposite-polarity edge code. It then samples the output at the first settled point after the write, and again one cycle later. The main sweep runs every one of the eight sense codes on pins in two enable banks, with the enable both set and clear. It drives a full low-high-low cycle on each and checks both the transition cycle and the settled cycle against a model computed in the bench.

// File: rtl/wakeIrqPkg.sv
package wakeIrqPkg;

  typedef enum logic [2:0] {
    SENSE_LVL_LOW  = 3'b000,
    SENSE_FALL     = 3'b010,
    SENSE_LVL_HIGH = 3'b100,
    SENSE_RISE     = 3'b110,
    SENSE_BOTH     = 3'b111
  } senseCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       cfgWr;    // a configuration word is written this cycle
    logic [7:0] cfgPin;   // which pin
    logic [2:0] cfgCode;  // its new sense code
  } ctrlStrobe_t;

  // high when the code asks for polarity inversion (low level, falling edge)
  function automatic logic senseInverts(input logic [2:0] code);
    return ~code[2];
  endfunction

endpackage

// File: rtl/wakeIrqCtrl.sv
module wakeIrqCtrl
  import wakeIrqPkg::*;
#(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic [NUM_PINS-1:0]   enVec,
  output logic [3*NUM_PINS-1:0] cfgFlat,
  output ctrlStrobe_t           strobe
);

  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int EN_BASE   = 'h010;
  localparam int CFG_BASE  = 'h110;
  localparam int EN_END    = EN_BASE + 4 * NUM_BANKS;
  localparam int CFG_END   = CFG_BASE + 4 * NUM_PINS;

  logic        wordAligned;
  logic        enHit;
  logic        cfgHit;
  int          enBank;
  int          cfgIdx;

  always_comb begin
    wordAligned = (regAddr[1:0] == 2'b00);
    enHit  = wordAligned && (int'(regAddr) >= EN_BASE)  && (int'(regAddr) < EN_END);
    cfgHit = wordAligned && (int'(regAddr) >= CFG_BASE) && (int'(regAddr) < CFG_END);
    enBank = (int'(regAddr) - EN_BASE) / 4;
    cfgIdx = (int'(regAddr) - CFG_BASE) / 4;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    localparam int BANK = p / DATA_W;
    localparam int BIT  = p % DATA_W;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        enVec[p] <= 1'b0;
      else if (regWrEn && enHit && enBank == BANK)
        enVec[p] <= regWrData[BIT];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgFlat[3*p +: 3] <= 3'b000;
      else if (regWrEn && cfgHit && cfgIdx == p)
        cfgFlat[3*p +: 3] <= regWrData[2:0];
    end
  end

  always_comb begin
    regRdData = '0;
    if (enHit) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (p / DATA_W == enBank) regRdData[p % DATA_W] = enVec[p];
    end else if (cfgHit) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (p == cfgIdx) regRdData[2:0] = cfgFlat[3*p +: 3];
    end
  end

  always_comb begin
    strobe.cfgWr   = regWrEn && cfgHit;
    strobe.cfgPin  = 8'(cfgIdx);
    strobe.cfgCode = regWrData[2:0];
  end

endmodule

// File: rtl/wakeIrqDatapath.sv
module wakeIrqDatapath
  import wakeIrqPkg::*;
#(
  parameter int NUM_PINS = 126
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-1:0]   enVec,
  input  logic [3*NUM_PINS-1:0] cfgFlat,
  input  ctrlStrobe_t           strobe,
  output logic [NUM_PINS-1:0]   irqOut
);

  logic [NUM_PINS-1:0] syncA;
  logic [NUM_PINS-1:0] syncQ;
  logic [NUM_PINS-1:0] prevQ;   // previous polarity-corrected value

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncQ <= '0;
    end else begin
      syncA <= pinIn;
      syncQ <= syncA;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    logic [2:0] code;
    logic       corr;
    logic       sensed;

    assign code = cfgFlat[3*p +: 3];
    assign corr = syncQ[p] ^ senseInverts(code);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        prevQ[p] <= 1'b0;
      else if (strobe.cfgWr && strobe.cfgPin == 8'(p))
        prevQ[p] <= syncQ[p] ^ senseInverts(strobe.cfgCode);
      else
        prevQ[p] <= corr;
    end

    always_comb begin
      unique case (code)
        SENSE_LVL_LOW, SENSE_LVL_HIGH: sensed = corr;
        SENSE_FALL, SENSE_RISE:        sensed = corr & ~prevQ[p];
        SENSE_BOTH:                    sensed = corr ^ prevQ[p];
        default:                       sensed = 1'b0;
      endcase
    end

    assign irqOut[p] = enVec[p] & sensed;
  end

endmodule

// File: rtl/wakeIrqNormalizer.sv
module wakeIrqNormalizer
  import wakeIrqPkg::*;
#(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] irqOut
);

  logic [NUM_PINS-1:0]   enVec;
  logic [3*NUM_PINS-1:0] cfgFlat;
  ctrlStrobe_t           strobe;

  wakeIrqCtrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .enVec(enVec), .cfgFlat(cfgFlat), .strobe(strobe)
  );

  wakeIrqDatapath #(.NUM_PINS(NUM_PINS)) uData (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .enVec(enVec),
    .cfgFlat(cfgFlat), .strobe(strobe), .irqOut(irqOut)
  );

endmodule

// File: rtl/wakeIrqChecker.sv
module wakeIrqChecker #(
  parameter int NUM_PINS = 126
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_PINS-1:0]   pinIn,
  input logic [NUM_PINS-1:0]   irqOut,
  input logic [NUM_PINS-1:0]   enVec,
  input logic [3*NUM_PINS-1:0] cfgFlat
);

  // cycles since reset release, saturating; $past below looks back three edges
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R10: a disabled pin stays quiet
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~enVec) == '0);

  for (genvar p = 0; p < NUM_PINS; p++) begin : gChk
    logic [2:0] code;
    assign code = cfgFlat[3*p +: 3];

    // R4
    a_r4_level_follows: assert property (@(posedge clk) disable iff (!rstN)
      (warm == 2'd3 && code == 3'b100) |-> irqOut[p] == (enVec[p] & $past(pinIn[p], 2)));

    // R5
    a_r5_low_inverts: assert property (@(posedge clk) disable iff (!rstN)
      (warm == 2'd3 && code == 3'b000) |-> irqOut[p] == (enVec[p] & ~$past(pinIn[p], 2)));

    // R6
    a_r6_rise_is_real: assert property (@(posedge clk) disable iff (!rstN)
      (warm == 2'd3 && code == 3'b110 && irqOut[p]) |-> ($past(pinIn[p], 2) && !$past(pinIn[p], 3)));

    // R9
    a_r9_undef_low: assert property (@(posedge clk) disable iff (!rstN)
      (code == 3'b001 || code == 3'b011 || code == 3'b101) |-> !irqOut[p]);
  end

endmodule

bind wakeIrqNormalizer wakeIrqChecker #(.NUM_PINS(NUM_PINS)) uChk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .irqOut(irqOut),
  .enVec(enVec), .cfgFlat(cfgFlat)
);

// File: tb/sim_wakeIrqNormalizer.sv
module sim_wakeIrqNormalizer;

  localparam int PERIOD = 10;
  localparam int NP     = 36;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  wakeIrqNormalizer #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn), .irqOut(irqOut)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkRead(input string req, input logic [11:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    total++;
    if (regRdData !== exp) begin
      bad++;
      $display("FAIL %s read 0x%03h: actual=0x%08h expected=0x%08h", req, a, regRdData, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic [NP-1:0] exp);
    total++;
    if (irqOut !== exp) begin
      bad++;
      $display("FAIL %s irqOut: actual=0x%09h expected=0x%09h", req, irqOut, exp);
    end
  endtask

  // model of one pin: cur = synchronized input, prv = its value one cycle earlier
  function automatic logic model(input int code, input logic cur, input logic prv);
    case (code)
      0:       return ~cur;          // R5
      4:       return cur;           // R4
      6:       return cur & ~prv;    // R6
      2:       return ~cur & prv;    // R7
      7:       return cur ^ prv;     // R8
      default: return 1'b0;          // R9
    endcase
  endfunction

  function automatic string reqOf(input int code, input bit en);
    if (!en) return "R10";
    case (code)
      0: return "R5";
      4: return "R4";
      6: return "R6";
      2: return "R7";
      7: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [11:0] cfgAddr(input int p);
    return 12'('h110 + 4 * p);
  endfunction

  function automatic logic [11:0] enAddr(input int p);
    return 12'('h10 + 4 * (p / 32));
  endfunction

  function automatic logic [NP-1:0] place(input int p, input logic v);
    logic [NP-1:0] r = '0;
    r[p] = v;
    return r;
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pins[4] = '{0, 5, 33, 35};
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1: reset state
    checkOut("R1", '0);
    checkRead("R1", 12'h010, 32'h0);
    checkRead("R1", 12'h014, 32'h0);
    checkRead("R1", cfgAddr(0), 32'h0);
    checkRead("R1", cfgAddr(35), 32'h0);

    // R2: bank mapping and unimplemented bits
    regWrite(12'h014, 32'hFFFF_FFFF);
    checkRead("R2", 12'h014, 32'h0000_000F);
    regWrite(12'h010, 32'hA5A5_A5A5);
    checkRead("R2", 12'h010, 32'hA5A5_A5A5);
    checkRead("R2", 12'h014, 32'h0000_000F);
    regWrite(12'h010, 32'h0);
    regWrite(12'h014, 32'h0);
    checkRead("R2", 12'h014, 32'h0);

    // R3: configuration storage, width and unmapped reads
    regWrite(cfgAddr(3), 32'hFFFF_FFFF);
    checkRead("R3", cfgAddr(3), 32'h7);
    regWrite(cfgAddr(35), 32'hFFFF_FFF5);
    checkRead("R3", cfgAddr(35), 32'h5);
    checkRead("R3", cfgAddr(36), 32'h0);
    checkRead("R3", 12'h000, 32'h0);
    regWrite(cfgAddr(3), 32'h0);
    regWrite(cfgAddr(35), 32'h0);

    // sweep: every code, pins in two banks, enable set and clear
    foreach (pins[k]) begin
      for (int code = 0; code < 8; code++) begin
        for (int e = 0; e < 2; e++) begin
          int p = pins[k];
          bit en = (e == 1);
          string rq = reqOf(code, en);
          pinIn = '0;
          regWrite(cfgAddr(p), 32'(code));
          regWrite(enAddr(p), en ? (32'h1 << (p % 32)) : 32'h0);
          tick(3);
          checkOut(rq, place(p, en & model(code, 1'b0, 1'b0)));
          pinIn[p] = 1'b1;
          tick(2);
          checkOut(rq, place(p, en & model(code, 1'b1, 1'b0)));
          tick(1);
          checkOut(rq, place(p, en & model(code, 1'b1, 1'b1)));
          pinIn[p] = 1'b0;
          tick(2);
          checkOut(rq, place(p, en & model(code, 1'b0, 1'b1)));
          tick(1);
          checkOut(rq, place(p, en & model(code, 1'b0, 1'b0)));
          regWrite(enAddr(p), 32'h0);
          regWrite(cfgAddr(p), 32'h0);
        end
      end
    end

    // R11: sense change on a steady pin creates no event
    pinIn = '0;
    regWrite(cfgAddr(5), 32'h6);
    regWrite(enAddr(5), 32'h20);
    tick(3);
    checkOut("R11", '0);
    regWrite(cfgAddr(5), 32'h2);          // rising -> falling with pin low
    checkOut("R11", '0);
    tick(1);
    checkOut("R11", '0);
    pinIn[5] = 1'b1;
    tick(3);
    checkOut("R11", '0);                  // rise under falling code: nothing
    regWrite(cfgAddr(5), 32'h6);          // falling -> rising with pin high
    checkOut("R11", '0);
    tick(1);
    checkOut("R11", '0);
    regWrite(cfgAddr(5), 32'h0);          // low level, pin high: inactive
    checkOut("R11", '0);
    regWrite(cfgAddr(5), 32'h7);          // either edge, pin steady
    checkOut("R11", '0);
    tick(1);
    checkOut("R11", '0);
    pinIn[5] = 1'b0;
    tick(2);
    checkOut("R8", place(5, 1'b1));       // real edge still seen after the change
    tick(1);
    checkOut("R8", '0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule